// File: doc/BRIEF.md
# Isochronous Transmit Buffer with Packet Key Tagging

This block sits between a byte-wide audio/video input port and an isochronous packet transmitter. Bytes arrive one per cycle with start-of-packet and end-of-packet markers. They are packed into 32-bit quadlets, and each quadlet is queued in a quadlet-deep buffer together with two sideband bits: the packet's odd/even encryption key and an end-of-packet flag. Because every entry carries its own key, several packets with different keys can wait in the buffer at once and each still leaves with its own key.

The key input is sampled once, on the edge that accepts a packet's first byte. Later changes on that input have no effect until the next packet starts. On the read side the buffer presents the head quadlet with its key and end marker, and forms the 4-bit sync nibble for the outgoing header from the head packet's key. A 32-bit status word gives occupancy threshold flags. All flags are decoded from one registered quadlet count. Writes that find the buffer full are discarded and set a sticky overflow output.

Top module: `iso_tx_keybuf`

## Requirements
- R1: On the rising edge where `inValid` and `inFirst` are both high, `keyIn` is captured as the packet's key (0 = even, 1 = odd).
- R2: Every quadlet of a packet carries the captured key, both when it is written and when it is presented at `outKey`, whatever `keyIn` does after the first byte.
- R3: `syncField` is {2'b00, key of head quadlet, 1'b0} while `outValid` is high, and 4'h0 while the buffer is empty.
- R4: Bytes are packed most significant byte first, so the first byte of a quadlet lands in bits 31:24. In a packet's final quadlet, unfilled lanes are zero. `outLast` is high only on a packet's final quadlet.
- R5: Status bit 0 (empty) is 1 exactly when zero quadlets are stored.
- R6: Status bit 3 (full) is 1 exactly when DEPTH quadlets are stored. Status bit 2 is 1 exactly when one quadlet of space remains.
- R7: Status bit 1 is 1 exactly when five or more quadlets of space remain.
- R8: Status bit 4 is 1 when at least DEPTH/2 quadlets are stored. Bit 5 is 1 when at most LEFT_HI quadlets of space remain. Bit 6 is 1 when at most LEFT_LO quadlets of space remain. Bits 31:7 are 0.
- R9: After reset the status word is 32'h0000_0003, `outValid` is 0 and `overflow` is 0.
- R10: A quadlet completed while full is discarded and leaves the stored contents unchanged. `overflow` then goes to 1 and stays at 1 until reset.
- R11: When a quadlet completes in the same cycle as a pop, the count is unchanged. The flags follow the count in the cycle after the edge.
- R12: Queued packets with different keys leave in write order, each with its own key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte valid |
| inByte | input | 8 | Input byte |
| inFirst | input | 1 | Byte is first of a packet |
| inLast | input | 1 | Byte is last of a packet |
| keyIn | input | 1 | Odd/even key level |
| outReady | input | 1 | Pop the head quadlet |
| outValid | output | 1 | Head quadlet present |
| outData | output | 32 | Head quadlet |
| outKey | output | 1 | Key of head quadlet's packet |
| outLast | output | 1 | Head quadlet ends its packet |
| syncField | output | 4 | Header sync nibble |
| statusWord | output | 32 | Occupancy flags |
| overflow | output | 1 | Sticky dropped-write indication |

## Verification
The bench builds the buffer with DEPTH = 16, LEFT_HI = 6 and LEFT_LO = 3. With these values a fill from empty to full passes every threshold edge in sixteen quadlets: five-free, half, both low-space marks, almost full and full. The same small depth lets the bench reach overflow and then drain the whole buffer, which shows that the dropped quadlet never entered storage.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;

  typedef struct packed {
    logic       loadByte;
    logic [1:0] lane;
    logic       pushEn;
    logic       popEn;
    logic       wordKey;
    logic       wordLast;
  } bufStrobes_t;

  typedef struct packed {
    logic [31:0] data;
    logic        key;
    logic        last;
  } bufEntry_t;

  localparam int STAT_EMPTY = 0;
  localparam int STAT_FIVE  = 1;
  localparam int STAT_AFULL = 2;
  localparam int STAT_FULL  = 3;
  localparam int STAT_HALF  = 4;
  localparam int STAT_LHI   = 5;
  localparam int STAT_LLO   = 6;

endpackage

// File: rtl/iso_tx_ctrl.sv
module iso_tx_ctrl
  import iso_tx_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int LEFT_HI = 256,
  parameter int LEFT_LO = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inFirst,
  input  logic        inLast,
  input  logic        keyIn,
  input  logic        outReady,
  output bufStrobes_t strobes,
  output logic        outValid,
  output logic [31:0] statusWord,
  output logic        overflow
);

  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [CW-1:0] HI_CNT   = CW'(LEFT_HI);
  localparam logic [CW-1:0] LO_CNT   = CW'(LEFT_LO);

  logic [CW-1:0] count;
  logic [CW-1:0] freeCnt;
  logic [1:0]    laneQ;
  logic [1:0]    curLane;
  logic          pktKeyQ;
  logic          lastLane;
  logic          wantPush;
  logic          empty, full, almostFull, fiveFree, halfFull, leftHi, leftLo;

  assign curLane  = inFirst ? 2'd0 : laneQ;
  assign lastLane = (curLane == 2'd3) || inLast;
  assign wantPush = inValid && lastLane;

  assign freeCnt    = FULL_CNT - count;
  assign empty      = (count == '0);
  assign full       = (count == FULL_CNT);
  assign almostFull = (freeCnt == CW'(1));
  assign fiveFree   = (freeCnt >= CW'(5));
  assign halfFull   = (count >= HALF_CNT);
  assign leftHi     = (freeCnt <= HI_CNT);
  assign leftLo     = (freeCnt <= LO_CNT);

  always_comb begin
    strobes          = '0;
    strobes.loadByte = inValid;
    strobes.lane     = curLane;
    strobes.pushEn   = wantPush && !full;
    strobes.popEn    = outReady && !empty;
    strobes.wordKey  = inFirst ? keyIn : pktKeyQ;
    strobes.wordLast = inLast;
  end

  assign outValid = !empty;

  always_comb begin
    statusWord             = '0;
    statusWord[STAT_EMPTY] = empty;
    statusWord[STAT_FIVE]  = fiveFree;
    statusWord[STAT_AFULL] = almostFull;
    statusWord[STAT_FULL]  = full;
    statusWord[STAT_HALF]  = halfFull;
    statusWord[STAT_LHI]   = leftHi;
    statusWord[STAT_LLO]   = leftLo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneQ   <= 2'd0;
      pktKeyQ <= 1'b0;
    end else if (inValid) begin
      laneQ <= lastLane ? 2'd0 : curLane + 2'd1;
      if (inFirst) pktKeyQ <= keyIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      case ({strobes.pushEn, strobes.popEn})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (wantPush && full) overflow <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R6

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({empty, almostFull, full})); // R6

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (full && !outReady) |=> full); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R10

  AST_SIMUL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pushEn && strobes.popEn) |=> $stable(statusWord)); // R11

endmodule

// File: rtl/iso_tx_dpath.sv
module iso_tx_dpath
  import iso_tx_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  bufStrobes_t strobes,
  input  logic [7:0]  inByte,
  output bufEntry_t   headEntry
);

  localparam int AW = $clog2(DEPTH);

  bufEntry_t   mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [31:0]   packReg;
  logic [31:0]   assembled;
  bufEntry_t     newEntry;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    always_comb begin
      if (2'(g) < strobes.lane)
        assembled[31-8*g -: 8] = packReg[31-8*g -: 8];
      else if (2'(g) == strobes.lane)
        assembled[31-8*g -: 8] = inByte;
      else
        assembled[31-8*g -: 8] = 8'h00;
    end
  end

  assign newEntry.data = assembled;
  assign newEntry.key  = strobes.wordKey;
  assign newEntry.last = strobes.wordLast;

  always_ff @(posedge clk) begin
    if (!rstN) packReg <= '0;
    else if (strobes.loadByte) packReg <= assembled;
  end

  always_ff @(posedge clk) begin
    if (strobes.pushEn) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.pushEn) wrPtr <= wrPtr + AW'(1);
      if (strobes.popEn)  rdPtr <= rdPtr + AW'(1);
    end
  end

  assign headEntry = mem[rdPtr];

  AST_PTR_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushEn |=> (wrPtr == $past(wrPtr) + AW'(1))); // R12

endmodule

// File: rtl/iso_tx_keybuf.sv
module iso_tx_keybuf
  import iso_tx_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int LEFT_HI = 256,
  parameter int LEFT_LO = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  input  logic        inFirst,
  input  logic        inLast,
  input  logic        keyIn,
  input  logic        outReady,
  output logic        outValid,
  output logic [31:0] outData,
  output logic        outKey,
  output logic        outLast,
  output logic [3:0]  syncField,
  output logic [31:0] statusWord,
  output logic        overflow
);

  bufStrobes_t strobes;
  bufEntry_t   headEntry;

  iso_tx_ctrl #(.DEPTH(DEPTH), .LEFT_HI(LEFT_HI), .LEFT_LO(LEFT_LO)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
    .inLast(inLast), .keyIn(keyIn), .outReady(outReady), .strobes(strobes),
    .outValid(outValid), .statusWord(statusWord), .overflow(overflow)
  );

  iso_tx_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inByte(inByte),
    .headEntry(headEntry)
  );

  assign outData   = headEntry.data;
  assign outKey    = headEntry.key;
  assign outLast   = headEntry.last;
  assign syncField = outValid ? {2'b00, headEntry.key, 1'b0} : 4'h0;

  AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rstN || overflow)
    (outValid && outReady && !outLast) |=> (!outValid || outKey == $past(outKey))); // R2

  AST_SYNC_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (syncField == 4'h0)); // R3

endmodule

// File: tb/sim_iso_tx_keybuf.sv
module sim_iso_tx_keybuf;

  localparam int D   = 16;
  localparam int LHI = 6;
  localparam int LLO = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        inFirst = 1'b0;
  logic        inLast = 1'b0;
  logic        keyIn = 1'b0;
  logic        outReady = 1'b0;
  logic        outValid;
  logic [31:0] outData;
  logic        outKey;
  logic        outLast;
  logic [3:0]  syncField;
  logic [31:0] statusWord;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  int modelCount = 0;
  bit finished = 1'b0;
  logic [33:0] expQ[$];

  always #4 clk = ~clk;

  iso_tx_keybuf #(.DEPTH(D), .LEFT_HI(LHI), .LEFT_LO(LLO)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .inFirst(inFirst), .inLast(inLast), .keyIn(keyIn), .outReady(outReady),
    .outValid(outValid), .outData(outData), .outKey(outKey), .outLast(outLast),
    .syncField(syncField), .statusWord(statusWord), .overflow(overflow)
  );

  function automatic logic [31:0] expStatus(int cnt);
    logic [31:0] s = '0;
    int freeQ = D - cnt;
    s[0] = (cnt == 0);
    s[1] = (freeQ >= 5);
    s[2] = (freeQ == 1);
    s[3] = (cnt == D);
    s[4] = (cnt >= D / 2);
    s[5] = (freeQ <= LHI);
    s[6] = (freeQ <= LLO);
    return s;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendPacket(int nBytes, logic key, logic [7:0] seed, bit flipKey);
    logic [31:0] word = '0;
    int lane = 0;
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inByte  = seed + 8'(i);
      inFirst = (i == 0);
      inLast  = (i == nBytes - 1);
      keyIn   = (i == 0) ? key : (flipKey ? ~key : key);
      word[31-8*lane -: 8] = seed + 8'(i);
      if (lane == 3 || i == nBytes - 1) begin
        if (modelCount < D) begin
          expQ.push_back({word, key, (i == nBytes - 1)});
          modelCount++;
        end
        word = '0;
        lane = 0;
      end else begin
        lane++;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inFirst = 1'b0;
    inLast  = 1'b0;
    keyIn   = ~key;
  endtask

  task automatic drain(int n, string req);
    for (int k = 0; k < n; k++) begin
      logic [33:0] e = expQ.pop_front();
      check(outValid == 1'b1, req, outValid, 1);
      check(outData == e[33:2], req, outData, e[33:2]);
      check(outKey == e[1], "R2", outKey, e[1]);
      check(outLast == e[0], "R4", outLast, e[0]);
      check(syncField == {2'b00, e[1], 1'b0}, "R3", syncField, {2'b00, e[1], 1'b0});
      outReady = 1'b1;
      @(negedge clk);
      outReady = 1'b0;
      modelCount--;
    end
  endtask

  task automatic testReset();
    check(statusWord == 32'h3, "R9", statusWord, 32'h3);
    check(outValid == 1'b0, "R9", outValid, 0);
    check(overflow == 1'b0, "R9", overflow, 0);
    check(syncField == 4'h0, "R3", syncField, 0);
    check(statusWord[0] == 1'b1, "R5", statusWord, 1);
  endtask

  task automatic testPackKey();
    sendPacket(6, 1'b1, 8'hA0, 1'b1);
    check(statusWord == expStatus(2), "R5", statusWord, expStatus(2));
    check(outData == 32'hA0A1A2A3, "R4", outData, 32'hA0A1A2A3);
    check(outKey == 1'b1, "R1", outKey, 1);
    drain(2, "R4");
    sendPacket(3, 1'b0, 8'h10, 1'b1);
    check(outData == 32'h10111200, "R4", outData, 32'h10111200);
    check(outKey == 1'b0, "R1", outKey, 0);
    drain(1, "R4");
  endtask

  task automatic testMultiKey();
    sendPacket(4, 1'b0, 8'h20, 1'b1);
    sendPacket(3, 1'b1, 8'h30, 1'b1);
    sendPacket(8, 1'b0, 8'h40, 1'b1);
    sendPacket(1, 1'b1, 8'h50, 1'b0);
    drain(5, "R12");
    check(statusWord == 32'h3, "R5", statusWord, 32'h3);
  endtask

  task automatic testSimul();
    logic [33:0] e;
    for (int p = 0; p < 5; p++) sendPacket(4, 1'(p), 8'(8'h60 + 4 * p), 1'b0);
    check(statusWord == expStatus(5), "R11", statusWord, expStatus(5));
    e = expQ.pop_front();
    check(outData == e[33:2], "R11", outData, e[33:2]);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inValid  = 1'b1;
      inByte   = 8'h80 + 8'(i);
      inFirst  = (i == 0);
      inLast   = (i == 3);
      keyIn    = 1'b1;
      outReady = (i == 3);
    end
    expQ.push_back({32'h80818283, 1'b1, 1'b1});
    @(negedge clk);
    inValid  = 1'b0;
    inFirst  = 1'b0;
    inLast   = 1'b0;
    outReady = 1'b0;
    check(statusWord == expStatus(5), "R11", statusWord, expStatus(5));
    drain(5, "R11");
    check(statusWord == 32'h3, "R11", statusWord, 32'h3);
  endtask

  task automatic testFlags();
    for (int q = 1; q <= D; q++) begin
      sendPacket(4, 1'(q), 8'(4 * q), 1'b0);
      check(statusWord == expStatus(q), "R8", statusWord, expStatus(q));
      if (q == D - 1) check(statusWord[2] == 1'b1, "R6", statusWord, 32'h4);
      if (q == D - 5) check(statusWord[1] == 1'b1, "R7", statusWord, 32'h2);
      if (q == D - 4) check(statusWord[1] == 1'b0, "R7", statusWord, 0);
      if (q == D) check(statusWord[3] == 1'b1, "R6", statusWord, 32'h8);
    end
    check(overflow == 1'b0, "R10", overflow, 0);
    sendPacket(4, 1'b0, 8'hF0, 1'b0);
    check(overflow == 1'b1, "R10", overflow, 1);
    check(statusWord == expStatus(D), "R10", statusWord, expStatus(D));
    drain(D, "R10");
    check(outValid == 1'b0, "R10", outValid, 0);
    check(overflow == 1'b1, "R10", overflow, 1);
    check(statusWord == 32'h3, "R5", statusWord, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPackKey();
    testMultiKey();
    testSimul();
    testFlags();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule